// File: doc/BRIEF.md
# Multi-Source Trigger Condition Detector

This block turns four possible trigger sources into one-shot trigger pulses, one per output channel. Two sources are external pins, called Ti (pin 0) and To (pin 1). For each pin, the configuration word can select low level, high level, any edge, rising edge or falling edge, in any mix. The other two sources are an ADC trigger line and a logic-analyzer trigger line, and each counts as asserted while it is high. Each of the four sources has its own enable bit. The qualified sources are ORed into a single `hit`.

All four source lines pass through a two-flop synchroniser into the clock domain. One more registered copy of each synchronised pin feeds the edge detection. `hit` drives one small state machine per channel. Each machine has three states: `ST_ARMED`, `ST_FIRE` and `ST_SPENT`.
- Reset places every channel in `ST_ARMED`.
- `ST_ARMED -> ST_FIRE` happens when `hit` is seen. `trig_out` is high only in `ST_FIRE`, so each firing gives a one-cycle pulse.
- `ST_FIRE -> ST_ARMED` happens when a re-arm is present in that cycle. Otherwise the transition is `ST_FIRE -> ST_SPENT`.
- `ST_SPENT -> ST_ARMED` happens on a re-arm. Without one, the machine stays in `ST_SPENT` and ignores `hit`.

A re-arm for a channel is either the shared `rearm_in` pulse or, when auto-rearm is enabled, that channel's own `last_in` bit.

Top module: `trig_detect`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, both `trig_out` bits are 0 and every channel is armed.
- R2: `cfg_word[0]` selects low-level detection on pin 0 (Ti) and `cfg_word[1]` selects it on pin 1 (To).
- R3: `cfg_word[2]` and `cfg_word[3]` select high-level detection on pin 0 and pin 1.
- R4: `cfg_word[4]` and `cfg_word[5]` select any-edge detection on pin 0 and pin 1.
- R5: `cfg_word[6]` and `cfg_word[7]` select rising-edge detection (0 to 1) on pin 0 and pin 1.
- R6: `cfg_word[8]` and `cfg_word[9]` select falling-edge detection (1 to 0) on pin 0 and pin 1.
- R7: A pin contributes to the trigger only while its enable bit is set: `cfg_word[16]` for pin 0 and `cfg_word[17]` for pin 1. A mode bit with its enable bit clear produces no pulse.
- R8: `cfg_word[18]` enables `adc_trig_in` and `cfg_word[19]` enables `la_trig_in`. An enabled line triggers while it is high, and a disabled line never triggers.
- R9: If an input change is set up before rising edge k, the resulting `trig_out` pulse is high after edge k+2 and low again after edge k+3.
- R10: An armed channel fires exactly once. After that it gives no further pulse until it is re-armed, even if the condition stays true.
- R11: A one-cycle pulse on `rearm_in` re-arms every channel. A condition that is still true then fires again.
- R12: When `cfg_word[20]` is set, `last_in[c]` re-arms channel c only. When `cfg_word[20]` is clear, `last_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the DAC domain |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Mode bits, source enables and auto-rearm bit |
| pin_in | input | 2 | Asynchronous external trigger pins: bit 0 is Ti, bit 1 is To |
| adc_trig_in | input | 1 | ADC trigger line, asynchronous |
| la_trig_in | input | 1 | Logic-analyzer trigger line, asynchronous |
| rearm_in | input | 1 | Software re-arm pulse for all channels |
| last_in | input | N_CHAN | Last-sample indication, one bit per channel |
| trig_out | output | N_CHAN | One-cycle trigger pulse, one bit per channel |

## Verification
A channel that is wrongly stuck in `ST_SPENT` shows at the ports as a missing pulse. It can be seen in the third cycle after a qualifying input change, or right after a re-arm while the condition still holds. A channel that is wrongly left armed, or that sits in `ST_FIRE` for too long, shows as a second pulse or a pulse wider than one cycle while the condition is held. It can be seen one cycle after the first pulse. Wrong decoding of a mode bit or an enable bit changes the count of pulses for a given pair of old and new pin levels. For that reason the bench sweeps every pin, mode, level pair and enable setting, and compares each count with the count the requirements predict.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int CFG_W       = 32;
    localparam int N_PINS      = 2;
    localparam int N_AUX       = 2;

    // Bit positions in the configuration word. A field is indexed by pin,
    // with pin 0 at its lowest bit.
    localparam int LOW_LSB     = 0;
    localparam int HIGH_LSB    = 2;
    localparam int ANY_LSB     = 4;
    localparam int RISE_LSB    = 6;
    localparam int FALL_LSB    = 8;
    localparam int EN_PIN_LSB  = 16;
    localparam int EN_ADC_BIT  = 18;
    localparam int EN_LA_BIT   = 19;
    localparam int AUTO_RE_BIT = 20;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_SPENT = 2'd2
    } arm_state_e;

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);

    logic [STAGES-1:0][W-1:0] stage_q;
    logic [W-1:0]             prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q[0] <= '0;
        end else begin
            stage_q[0] <= din;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= stage_q[STAGES-1];
        end
    end

    assign cur  = stage_q[STAGES-1];
    assign prev = prev_q;

endmodule

// File: rtl/trig_cond.sv
module trig_cond
    import trig_pkg::*;
(
    input  logic [CFG_W-1:0]  cfg,
    input  logic [N_PINS-1:0] pin_cur,
    input  logic [N_PINS-1:0] pin_prev,
    input  logic              adc_cur,
    input  logic              la_cur,
    output logic              hit
);

    logic [N_PINS-1:0] pin_hit;

    generate
        for (genvar p = 0; p < N_PINS; p++) begin : g_pin
            logic lvl_lo, lvl_hi, edg_any, edg_rise, edg_fall;
            always_comb begin
                lvl_lo   = cfg[LOW_LSB + p]  & ~pin_cur[p];
                lvl_hi   = cfg[HIGH_LSB + p] &  pin_cur[p];
                edg_any  = cfg[ANY_LSB + p]  & (pin_cur[p] ^ pin_prev[p]);
                edg_rise = cfg[RISE_LSB + p] &  pin_cur[p] & ~pin_prev[p];
                edg_fall = cfg[FALL_LSB + p] & ~pin_cur[p] &  pin_prev[p];
                pin_hit[p] = cfg[EN_PIN_LSB + p] &
                             (lvl_lo | lvl_hi | edg_any | edg_rise | edg_fall);
            end
        end
    endgenerate

    always_comb begin
        hit = (|pin_hit)
            | (cfg[EN_ADC_BIT] & adc_cur)
            | (cfg[EN_LA_BIT]  & la_cur);
    end

endmodule

// File: rtl/trig_arm_fsm.sv
module trig_arm_fsm
    import trig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic rearm,
    output logic fire,
    output logic armed
);

    arm_state_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_ARMED: if (hit)   state_nx = ST_FIRE;
            ST_FIRE:  state_nx = rearm ? ST_ARMED : ST_SPENT;
            ST_SPENT: if (rearm) state_nx = ST_ARMED;
            default:  state_nx = ST_ARMED;
        endcase
    end

    always_comb begin
        fire  = (state_q == ST_FIRE);
        armed = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int N_CHAN      = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CFG_W-1:0]  cfg_word,
    input  logic [N_PINS-1:0] pin_in,
    input  logic              adc_trig_in,
    input  logic              la_trig_in,
    input  logic              rearm_in,
    input  logic [N_CHAN-1:0] last_in,
    output logic [N_CHAN-1:0] trig_out
);

    localparam int SRC_W = N_PINS + N_AUX;

    logic [SRC_W-1:0]  src_cur, src_prev;
    logic              hit_w;
    logic [N_CHAN-1:0] armed_w;
    logic [N_CHAN-1:0] rearm_w;

    trig_sync #(
        .W      (SRC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({la_trig_in, adc_trig_in, pin_in}),
        .cur  (src_cur),
        .prev (src_prev)
    );

    trig_cond u_cond (
        .cfg      (cfg_word),
        .pin_cur  (src_cur[N_PINS-1:0]),
        .pin_prev (src_prev[N_PINS-1:0]),
        .adc_cur  (src_cur[N_PINS]),
        .la_cur   (src_cur[N_PINS+1]),
        .hit      (hit_w)
    );

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
            assign rearm_w[c] = rearm_in | (cfg_word[AUTO_RE_BIT] & last_in[c]);

            trig_arm_fsm u_fsm (
                .clk   (clk),
                .rst   (rst),
                .hit   (hit_w),
                .rearm (rearm_w[c]),
                .fire  (trig_out[c]),
                .armed (armed_w[c])
            );
        end
    endgenerate

endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk
    import trig_pkg::*;
#(
    parameter int N_CHAN = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [CFG_W-1:0]  cfg_word,
    input logic              rearm_in,
    input logic [N_CHAN-1:0] last_in,
    input logic              hit,
    input logic [N_CHAN-1:0] armed,
    input logic [N_CHAN-1:0] trig_out
);

    // R1: reset leaves every output low and every channel armed
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (trig_out == '0) && (armed == {N_CHAN{1'b1}}));

    generate
        for (genvar c = 0; c < N_CHAN; c++) begin : g_c
            logic re_c;
            logic spent_q;
            assign re_c = rearm_in | (cfg_word[AUTO_RE_BIT] & last_in[c]);

            always_ff @(posedge clk) begin
                if (rst)           spent_q <= 1'b0;
                else if (re_c)     spent_q <= 1'b0;
                else if (trig_out[c]) spent_q <= 1'b1;
            end

            // R10: the pulse is exactly one cycle wide
            a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
                trig_out[c] |=> !trig_out[c]);

            // R10: no second pulse before a re-arm
            a_r10_no_refire: assert property (@(posedge clk) disable iff (rst)
                !(trig_out[c] && spent_q));

            // R9: an armed channel that sees hit pulses on the next cycle
            a_r9_hit_fires: assert property (@(posedge clk) disable iff (rst)
                (armed[c] && hit) |=> trig_out[c]);

            // R9: a pulse is always preceded by hit in the armed state
            a_r9_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
                $rose(trig_out[c]) |-> $past(armed[c] && hit));

            // R11, R12: a re-arm without a simultaneous firing leaves the channel armed
            a_r11_rearm_arms: assert property (@(posedge clk) disable iff (rst)
                (re_c && !(armed[c] && hit)) |=> armed[c]);
        end
    endgenerate

endmodule

bind trig_detect trig_detect_chk #(.N_CHAN(N_CHAN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_word (cfg_word),
    .rearm_in (rearm_in),
    .last_in  (last_in),
    .hit      (hit_w),
    .armed    (armed_w),
    .trig_out (trig_out)
);

// File: tb/trig_detect_tb.sv
module trig_detect_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_word = '0;
    logic [1:0]  pin_in = '0;
    logic        adc_trig_in = 1'b0;
    logic        la_trig_in = 1'b0;
    logic        rearm_in = 1'b0;
    logic [1:0]  last_in = '0;
    logic [1:0]  trig_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    trig_detect u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_word    (cfg_word),
        .pin_in      (pin_in),
        .adc_trig_in (adc_trig_in),
        .la_trig_in  (la_trig_in),
        .rearm_in    (rearm_in),
        .last_in     (last_in),
        .trig_out    (trig_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count pulses per channel over n cycles, sampling after each edge
    task automatic count_pulses(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c0 += int'(trig_out[0]);
            c1 += int'(trig_out[1]);
        end
    endtask

    task automatic pulse_rearm();
        rearm_in = 1'b1;
        @(negedge clk);
        rearm_in = 1'b0;
    endtask

    initial begin
        int c0, c1;
        @(negedge clk);
        // R1: output during reset
        check("R1 during reset", int'(trig_out), 0);
        cycles(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", int'(trig_out), 0);
        cycles(4);

        // Sweep R2..R7: pin, mode, old level, new level, enable
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 5; m++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int b = 0; b < 2; b++) begin
                        for (int en = 0; en < 2; en++) begin
                            bit cond;
                            logic [31:0] cw;
                            int exp;
                            string tag;
                            cfg_word = '0;
                            pin_in   = '0;
                            pin_in[p] = a[0];
                            cycles(5);
                            pulse_rearm();
                            cycles(1);
                            unique case (m)
                                0: begin cond = (a == 0) || (b == 0); tag = "R2 low level"; end
                                1: begin cond = (a == 1) || (b == 1); tag = "R3 high level"; end
                                2: begin cond = (a != b);             tag = "R4 any edge"; end
                                3: begin cond = (a == 0) && (b == 1); tag = "R5 rising edge"; end
                                default: begin cond = (a == 1) && (b == 0); tag = "R6 falling edge"; end
                            endcase
                            cw = '0;
                            cw[2*m + p] = 1'b1;
                            cw[16 + p]  = en[0];
                            exp = (cond && en == 1) ? 1 : 0;
                            if (en == 0) tag = "R7 disabled pin";
                            cfg_word = cw;
                            pin_in[p] = b[0];
                            count_pulses(10, c0, c1);
                            check(tag, c0, exp);
                            check(tag, c1, exp);
                        end
                    end
                end
            end
        end

        // R7: mode bit on pin 0 but only pin 1 enabled
        cfg_word = '0; pin_in = 2'b00; cycles(5); pulse_rearm();
        cfg_word = 32'h0000_0000 | (32'h1 << 2) | (32'h1 << 17);
        pin_in = 2'b01;
        count_pulses(10, c0, c1);
        check("R7 wrong pin enabled", c0, 0);

        // R9: latency of a rising edge on pin 1
        cfg_word = '0; pin_in = 2'b00; cycles(5); pulse_rearm();
        cfg_word = (32'h1 << 7) | (32'h1 << 17);
        cycles(2);
        pin_in = 2'b10;
        @(negedge clk); check("R9 after edge k", int'(trig_out), 0);
        @(negedge clk); check("R9 after edge k+1", int'(trig_out), 0);
        @(negedge clk); check("R9 after edge k+2", int'(trig_out), 3);
        @(negedge clk); check("R9 after edge k+3", int'(trig_out), 0);

        // R8: ADC and logic-analyzer lines
        cfg_word = '0; pin_in = '0; cycles(5); pulse_rearm();
        cfg_word = 32'h1 << 18; adc_trig_in = 1'b1;
        count_pulses(10, c0, c1); check("R8 adc enabled", c0, 1);
        cfg_word = '0; adc_trig_in = 1'b0; cycles(5); pulse_rearm();
        cfg_word = 32'h1 << 19; adc_trig_in = 1'b1;
        count_pulses(10, c0, c1); check("R8 adc disabled", c0, 0);
        adc_trig_in = 1'b0; la_trig_in = 1'b1;
        count_pulses(10, c0, c1); check("R8 la enabled", c1, 1);
        cfg_word = '0; cycles(5); pulse_rearm();
        cfg_word = 32'h1 << 18;
        count_pulses(10, c0, c1); check("R8 la disabled", c1, 0);
        la_trig_in = 1'b0;

        // R10, R11: held high level fires once, then again after rearm
        cfg_word = '0; pin_in = '0; cycles(5); pulse_rearm();
        cfg_word = (32'h1 << 2) | (32'h1 << 16); pin_in = 2'b01;
        count_pulses(20, c0, c1); check("R10 held condition", c0, 1);
        pulse_rearm();
        count_pulses(10, c0, c1);
        check("R11 rearm ch0", c0, 1);
        check("R11 rearm ch1", c1, 1);

        // R12: auto-rearm per channel, and ignored without bit 20
        last_in = 2'b01; @(negedge clk); last_in = 2'b00;
        count_pulses(10, c0, c1);
        check("R12 last ignored ch0", c0, 0);
        cfg_word[20] = 1'b1;
        last_in = 2'b01; @(negedge clk); last_in = 2'b00;
        count_pulses(10, c0, c1);
        check("R12 auto rearm ch0", c0, 1);
        check("R12 auto rearm ch1 untouched", c1, 0);
        last_in = 2'b10; @(negedge clk); last_in = 2'b00;
        count_pulses(10, c0, c1);
        check("R12 auto rearm ch1", c1, 1);
        check("R12 auto rearm ch0 untouched", c0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule